// File: doc/BRIEF.md
# Read Strobe Gate Delay Calibrator

This block searches for the delay of the internal read-strobe enable on each of four byte lanes, so that the enable rises inside the strobe preamble of a returning read burst. It repeats one pass at a time. In each pass it requests a burst read and receives a vector that marks each byte as correct or wrong. Every lane that read wrong moves one quarter cycle later. The four quarter-cycle counts are then repacked into a 32-bit gate word: the shared part is the smallest count, split into whole cycles and remaining quarters, and each lane adds a 2-bit offset to it. Between passes the block holds a controller reset for a programmable time so the read FIFO pointers line up again.

When a pass has every byte correct, every lane moves one quarter cycle further into the preamble, the word is rewritten, and one last read must still pass. The block then ends in a done state. It ends in an error state if the final read fails, or if the counts can no longer be encoded in the word. Writing the reference data and comparing the read data are done outside the block.

Top module: `strobe_gate_cal`

## Requirements
- R1: After reset, gate_cfg_o is 0, and done_o, err_o, rd_req_o and ctl_rst_o are all low.
- R2: start_i clears all four lane counts to zero and sets gate_cfg_o bit 31 (enable), with every delay field at 0. The enable bit stays set until the next reset.
- R3: Each pass raises rd_req_o for exactly one cycle. When rd_done_i arrives, each lane i whose rd_ok_i[i] is 0 increments its count by one, and every other lane keeps its count.
- R4: gate_cfg_o encodes the counts as follows. Let m be the minimum count. Bits [30:29] hold m/4 and bits [28:27] hold m mod 4. Lane i's offset (count minus m) is at bits [26-2i:25-2i], so lane 0 is [26:25] and lane 3 is [20:19].
- R5: After a failing pass, ctl_rst_o is high for max(rst_len_i, 2) consecutive cycles, and the next rd_req_o follows in the cycle after it falls. ctl_rst_o and rd_req_o are never high together.
- R6: When a pass has all four bytes correct, every count increments once, gate_cfg_o is rewritten, and one more read is issued with no reset pulse before it.
- R7: If that final read has all bytes correct, done_o is set. If it has any byte wrong, err_o is set instead.
- R8: If a lane offset would exceed 3, or m/4 would exceed 3, err_o is set, no further read or reset pulse follows, and gate_cfg_o keeps its last encodable value.
- R9: done_o and err_o are never high together, and both are cleared by start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin (or restart) calibration |
| rst_len_i | input | 8 | Controller reset pulse length in cycles, minimum 2 applied |
| rd_req_o | output | 1 | One-cycle burst read request |
| rd_done_i | input | 1 | Read result valid |
| rd_ok_i | input | 4 | Per-byte correct flags, bit i for lane i |
| ctl_rst_o | output | 1 | Controller reset pulse between passes |
| gate_cfg_o | output | 32 | Packed gate delay word |
| done_o | output | 1 | Calibration finished successfully |
| err_o | output | 1 | Calibration stopped on overflow or final failure |

## Verification
A lane count that is wrong by one quarter cycle appears in gate_cfg_o on the next encode, one cycle after the read result. A responder that passes a lane only when its decoded delay reaches a target then changes the number of reads and reset pulses. A pass that increments too few lanes or too many shows up as an extra or missing read, and as an offset field that no longer matches the differences between the targets. A fault in the reset timer changes the pulse width that is measured at ctl_rst_o. A missed overflow test lets reads continue after the point where err_o should have stopped them.

// File: rtl/strobe_gate_pkg.sv
package strobe_gate_pkg;
  localparam int NUM_LANES = 4;
  localparam int FLD_W     = 2;
  localparam int CNT_W     = 5;
  localparam int EN_BIT    = 31;
  localparam int CYC_LSB   = 29;
  localparam int QTR_LSB   = 27;
  localparam int OFF0_LSB  = 25;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_ENC, S_RST, S_DONE, S_ERR
  } cal_state_e;
endpackage

// File: rtl/sgc_encoder.sv
module sgc_encoder
  import strobe_gate_pkg::*;
(
  input  cnt_t        cnt_i [NUM_LANES],
  output logic [30:0] word_o,
  output logic        ovf_o
);
  cnt_t min_c;
  cnt_t off_c [NUM_LANES];

  always_comb begin
    min_c = cnt_i[0];
    for (int i = 1; i < NUM_LANES; i++)
      if (cnt_i[i] < min_c) min_c = cnt_i[i];
  end

  always_comb begin
    ovf_o  = (min_c >> 2) > cnt_t'(3);
    word_o = '0;
    word_o[CYC_LSB +: FLD_W] = min_c[3:2];
    word_o[QTR_LSB +: FLD_W] = min_c[1:0];
    for (int i = 0; i < NUM_LANES; i++) begin
      off_c[i] = cnt_i[i] - min_c;
      if (off_c[i] > cnt_t'(3)) ovf_o = 1'b1;
      word_o[OFF0_LSB - FLD_W*i +: FLD_W] = off_c[i][FLD_W-1:0];
    end
  end
endmodule

// File: rtl/sgc_pulse.sv
module sgc_pulse #(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             pulse_o,
  output logic             last_o
);
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (len_i < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           left_q <= '0;
    else if (fire_i)       left_q <= eff_len;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
  assign last_o  = (left_q == LEN_W'(1));

  // R5: the pulse lasts at least MIN_LEN cycles
  p_min_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $past(pulse_o, 2));
endmodule

// File: rtl/strobe_gate_cal.sv
module strobe_gate_cal
  import strobe_gate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     rst_len_i,
  output logic                 rd_req_o,
  input  logic                 rd_done_i,
  input  logic [NUM_LANES-1:0] rd_ok_i,
  output logic                 ctl_rst_o,
  output logic [31:0]          gate_cfg_o,
  output logic                 done_o,
  output logic                 err_o
);
  cal_state_e  state_q;
  logic        final_q;
  logic        en_q;
  logic [30:0] fields_q;
  cnt_t        cnt_q [NUM_LANES];
  logic [30:0] enc_word;
  logic        enc_ovf;
  logic        pulse_last;
  logic        idle_like;
  logic        take;

  assign idle_like = (state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_ERR);
  assign take      = (state_q == S_WAIT) && rd_done_i;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   cnt_q[g] <= '0;
        else if (idle_like && start_i) cnt_q[g] <= '0;
        else if (take && (final_q == 1'b0) && (!rd_ok_i[g] || (&rd_ok_i)))
          cnt_q[g] <= cnt_q[g] + 1'b1;
      end

      // R3: a count moves by at most one step per pass
      p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q[g] == $past(cnt_q[g])) || (cnt_q[g] == $past(cnt_q[g]) + 1'b1) || (cnt_q[g] == '0));
    end
  endgenerate

  sgc_encoder u_enc (
    .cnt_i  (cnt_q),
    .word_o (enc_word),
    .ovf_o  (enc_ovf)
  );

  sgc_pulse #(.LEN_W(LEN_W), .MIN_LEN(2)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  ((state_q == S_ENC) && !enc_ovf && !final_q),
    .len_i   (rst_len_i),
    .pulse_o (ctl_rst_o),
    .last_o  (pulse_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      final_q  <= 1'b0;
      en_q     <= 1'b0;
      fields_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE, S_ERR:
          if (start_i) begin
            state_q  <= S_ISSUE;
            final_q  <= 1'b0;
            en_q     <= 1'b1;
            fields_q <= '0;
          end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT:
          if (rd_done_i) begin
            if (final_q)        state_q <= (&rd_ok_i) ? S_DONE : S_ERR;
            else begin
              state_q <= S_ENC;
              if (&rd_ok_i) final_q <= 1'b1;
            end
          end
        S_ENC:
          if (enc_ovf) state_q <= S_ERR;
          else begin
            fields_q <= enc_word;
            state_q  <= final_q ? S_ISSUE : S_RST;
          end
        S_RST:
          if (pulse_last) state_q <= S_ISSUE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o   = (state_q == S_ISSUE);
  assign gate_cfg_o = {en_q, fields_q};
  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_ERR);

  // R5: never request a read while the controller is held in reset
  p_req_out_of_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && ctl_rst_o));
  // R3: read request is a single-cycle pulse
  p_req_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R9: terminal flags exclusive
  p_flags_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R2: enable bit never drops once set
  p_enable_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gate_cfg_o[EN_BIT]) |-> gate_cfg_o[EN_BIT]);
  // R8: no new request after an error stop
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> !rd_req_o && !ctl_rst_o);
endmodule

// File: tb/strobe_gate_cal_tb.sv
module strobe_gate_cal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WDOG       = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] rst_len_i = 8'd0;
  logic       rd_req_o;
  logic       rd_done_i = 1'b0;
  logic [3:0] rd_ok_i = 4'h0;
  logic       ctl_rst_o;
  logic [31:0] gate_cfg_o;
  logic       done_o;
  logic       err_o;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  int pulses = 0;
  int bad_len = 0;
  int exp_len = 2;
  int run = 0;
  int wait_cnt = 0;
  int cycles = 0;
  bit finished = 0;
  int need [4];
  int win = 3;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  strobe_gate_cal u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rst_len_i(rst_len_i),
    .rd_req_o(rd_req_o), .rd_done_i(rd_done_i), .rd_ok_i(rd_ok_i),
    .ctl_rst_o(ctl_rst_o), .gate_cfg_o(gate_cfg_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic int lane_delay(input logic [31:0] w, input int i);
    return int'(w[30:29]) * 4 + int'(w[28:27]) + int'(w[26-2*i -: 2]);
  endfunction

  function automatic logic [3:0] lane_ok(input logic [31:0] w);
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = (lane_delay(w, i) >= need[i]) && (lane_delay(w, i) <= need[i] + win);
    return r;
  endfunction

  function automatic logic [31:0] enc(input int c0, input int c1, input int c2, input int c3);
    int m;
    m = c0;
    if (c1 < m) m = c1;
    if (c2 < m) m = c2;
    if (c3 < m) m = c3;
    return {1'b1, 2'(m / 4), 2'(m % 4), 2'(c0 - m), 2'(c1 - m), 2'(c2 - m), 2'(c3 - m), 19'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory responder and reset pulse monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_done_i) rd_done_i = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          rd_done_i = 1'b1;
          rd_ok_i   = lane_ok(gate_cfg_o);
        end
      end
      if (rd_req_o) begin
        reads++;
        wait_cnt = LAT;
      end
      if (ctl_rst_o) run++;
      else if (run != 0) begin
        pulses++;
        if (run != exp_len) bad_len++;
        run = 0;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > WDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  task automatic run_cal(input int n0, input int n1, input int n2, input int n3,
                         input int w, input int len);
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    win = w;
    rst_len_i = 8'(len);
    exp_len = (len < 2) ? 2 : len;
    reads = 0; pulses = 0; bad_len = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!(done_o || err_o)) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 gate", gate_cfg_o, 32'h0);
    chk("R1 flags", {28'd0, done_o, err_o, rd_req_o, ctl_rst_o}, 32'h0);
  endtask

  task automatic t_start_enable();
    need[0] = 0; need[1] = 0; need[2] = 0; need[3] = 0; win = 3;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R2 enable set fields zero", gate_cfg_o, 32'h8000_0000);
    while (!(done_o || err_o)) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_immediate_pass();
    run_cal(0, 0, 0, 0, 3, 4);
    chk("R6 reads with no failing pass", 32'(reads), 32'd2);
    chk("R6 no reset pulse", 32'(pulses), 32'd0);
    chk("R7 done", {30'd0, done_o, err_o}, 32'd2);
    chk("R4 word after bump", gate_cfg_o, enc(1, 1, 1, 1));
  endtask

  task automatic t_skewed_lanes();
    run_cal(2, 5, 3, 4, 3, 0);
    chk("R3 reads", 32'(reads), 32'd7);
    chk("R5 pulse count", 32'(pulses), 32'd5);
    chk("R5 min width 2", 32'(bad_len), 32'd0);
    chk("R4 skew encode", gate_cfg_o, enc(3, 6, 4, 5));
    chk("R7 done", {30'd0, done_o, err_o}, 32'd2);
  endtask

  task automatic t_long_delays();
    run_cal(9, 9, 10, 11, 3, 6);
    chk("R4 cycles and quarters", gate_cfg_o, enc(10, 10, 11, 12));
    chk("R5 width 6", 32'(bad_len), 32'd0);
    chk("R5 pulse count", 32'(pulses), 32'd11);
  endtask

  task automatic t_offset_ovf();
    run_cal(0, 4, 1, 1, 3, 2);
    chk("R8 err on offset", {30'd0, done_o, err_o}, 32'd1);
    chk("R8 last good word", gate_cfg_o, enc(0, 3, 1, 1));
    chk("R8 reads stop", 32'(reads), 32'd4);
    chk("R8 no pulse after stop", 32'(pulses), 32'd3);
  endtask

  task automatic t_cycle_ovf();
    run_cal(15, 15, 15, 15, 3, 2);
    chk("R8 err on cycle count", {30'd0, done_o, err_o}, 32'd1);
    chk("R8 word kept", gate_cfg_o, enc(15, 15, 15, 15));
    chk("R8 no final read", 32'(reads), 32'd16);
  endtask

  task automatic t_final_fail();
    run_cal(1, 1, 1, 1, 0, 3);
    chk("R7 err on final read", {30'd0, done_o, err_o}, 32'd1);
    chk("R6 final read issued", 32'(reads), 32'd3);
    chk("R6 word after bump", gate_cfg_o, enc(2, 2, 2, 2));
  endtask

  task automatic t_restart();
    run_cal(1, 0, 0, 2, 3, 2);
    chk("R9 restart clears err", {30'd0, done_o, err_o}, 32'd2);
    chk("R2 counts restart from zero", gate_cfg_o, enc(2, 1, 1, 3));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_start_enable();
    t_immediate_pass();
    t_skewed_lanes();
    t_long_delays();
    t_offset_ovf();
    t_cycle_ovf();
    t_final_fail();
    t_restart();
    summary();
  end
endmodule